// File: doc/BRIEF.md
# Per-Class Detection Probability Engine

This block takes an M-by-M confusion matrix, one signed 32-bit count per element in row-major order, and produces one fixed-point detection probability per class. It makes a single pass over the stream. While a row streams in, it adds every count into a row sum. It also keeps the count whose column index matches the current row index, which is the number of correctly classified instances.

When a row ends, the block multiplies the kept diagonal count by a scale constant to a 64-bit product. A shift-and-subtract divider then divides that product by the row sum with signed, truncating division. The low 32 bits of the quotient come out on a valid/ready port, tagged with the row number. If a row sum is zero, the divider is skipped. That row gives a zero result with an error flag set.

A start pulse loads the dimension and the scale. Input is back-pressured while a row result is being computed or waiting to be taken. A done flag rises once the last row's result has been accepted.

Top module: `detprob_engine`

## Requirements
- R1: After reset `in_ready`, `out_valid` and `done` are all 0.
- R2: `in_ready` is 1 only while a row is being accumulated. From the cycle after a row's last element is accepted until that row's result is accepted, `in_ready` is 0, and `in_ready` and `out_valid` are never both 1.
- R3: For each row, `out_data` equals the low 32 bits of (diag * scale) / rowsum. The 64-bit product is signed and the division truncates toward zero. diag is the element whose column index equals the row index, and rowsum is the 32-bit wrapped sum of the row's elements.
- R4: Exactly M results are emitted, with `out_row` taking the values 0, 1, ..., M-1 in that order.
- R5: A row whose sum is zero gives `out_data` = 0 with `out_err` = 1. Every other row gives `out_err` = 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` = 1, and `out_data`, `out_row` and `out_err` unchanged.
- R7: `done` becomes 1 in the cycle after the last result is accepted and stays 1 until the next accepted start.
- R8: A start pulse while idle captures `dim_in` as M and `scale_in` as the scale for the whole matrix. A start with `dim_in` = 0 raises `done` in the next cycle and emits no result.
- R9: Negative counts are handled as signed values, so the quotient sign is the XOR of the product and row-sum signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a matrix (taken when idle) |
| dim_in | input | DIM_W | Matrix dimension M |
| scale_in | input | DW | Scale constant (signed) |
| in_valid | input | 1 | Element present |
| in_data | input | DW | Element count (signed) |
| in_ready | output | 1 | Element accepted when high with in_valid |
| out_valid | output | 1 | Row result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DW | Scaled detection probability |
| out_row | output | DIM_W | Row index of the result |
| out_err | output | 1 | Row sum was zero |
| done | output | 1 | All rows of the matrix delivered |

## Verification
The bench goes after a zero-sum row; a design without the bypass would hang in the divider or emit a garbage quotient. It feeds negative counts, which catch magnitude or sign-fixup errors as results with the wrong sign or rounded the wrong way. It uses dimensions 1 and 3 and a zero dimension, where an off-by-one in the column or row limit would shift the diagonal or emit too many or too few rows. Random stalls on both sides expose a design that drops elements during a divide, or lets the held result change before it is taken.

// File: rtl/detprob_engine.sv
module detprob_engine #(
  parameter int DW    = 32,
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] dim_in,
  input  logic [DW-1:0]    scale_in,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [DIM_W-1:0] out_row,
  output logic             out_err,
  output logic             done
);
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(PW) + 1;
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DIV, S_OUT} st_t;
  st_t st_q;

  logic [DIM_W-1:0] m_q, row_q, col_q;
  logic [DW-1:0]    scale_q, sum_q, diag_q, res_q;
  logic [PW-1:0]    quo_q, dsr_q;
  logic [PW:0]      rem_q;
  logic [CW-1:0]    cnt_q;
  logic             neg_q, err_q, done_q;

  assign in_ready  = st_q == S_ACC;
  assign out_valid = st_q == S_OUT;
  assign out_data  = res_q;
  assign out_row   = row_q;
  assign out_err   = err_q;
  assign done      = done_q;

  wire              acc_fire = in_ready && in_valid;
  wire              last_col = col_q == m_q - ONE;
  wire [DW-1:0]     diag_n   = (col_q == row_q) ? in_data : diag_q;
  wire [DW-1:0]     sum_n    = sum_q + in_data;

  logic signed [PW-1:0] diag_x, scale_x, sum_x, prod;
  assign diag_x  = {{DW{diag_n[DW-1]}}, diag_n};
  assign scale_x = {{DW{scale_q[DW-1]}}, scale_q};
  assign sum_x   = {{DW{sum_n[DW-1]}}, sum_n};
  assign prod    = diag_x * scale_x;

  wire [PW-1:0] prod_abs = prod[PW-1] ? -prod : prod;
  wire [PW-1:0] sum_abs  = sum_x[PW-1] ? -sum_x : sum_x;

  wire [PW:0]   rem_sh = {rem_q[PW-1:0], quo_q[PW-1]};
  wire [PW:0]   sub    = rem_sh - {1'b0, dsr_q};
  wire          ge     = !sub[PW];
  wire [PW-1:0] quo_nx = {quo_q[PW-2:0], ge};
  wire [DW-1:0] q_lo   = quo_nx[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      m_q <= '0; row_q <= '0; col_q <= '0;
      scale_q <= '0; sum_q <= '0; diag_q <= '0; res_q <= '0;
      quo_q <= '0; dsr_q <= '0; rem_q <= '0; cnt_q <= '0;
      neg_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          m_q <= dim_in; scale_q <= scale_in;
          row_q <= '0; col_q <= '0; sum_q <= '0; diag_q <= '0;
          if (dim_in == '0) done_q <= 1'b1;
          else begin
            done_q <= 1'b0;
            st_q   <= S_ACC;
          end
        end
        S_ACC: if (acc_fire) begin
          sum_q  <= sum_n;
          diag_q <= diag_n;
          col_q  <= col_q + ONE;
          if (last_col) begin
            if (sum_n == '0) begin
              res_q <= '0; err_q <= 1'b1; st_q <= S_OUT;
            end else begin
              err_q <= 1'b0;
              neg_q <= prod[PW-1] ^ sum_n[DW-1];
              quo_q <= prod_abs;
              dsr_q <= sum_abs;
              rem_q <= '0;
              cnt_q <= CW'(PW);
              st_q  <= S_DIV;
            end
          end
        end
        S_DIV: begin
          quo_q <= quo_nx;
          rem_q <= ge ? sub : rem_sh;
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            res_q <= neg_q ? -q_lo : q_lo;
            st_q  <= S_OUT;
          end
        end
        S_OUT: if (out_ready) begin
          if (row_q == m_q - ONE) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            row_q <= row_q + ONE;
            col_q <= '0; sum_q <= '0; diag_q <= '0;
            st_q  <= S_ACC;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_row) && $stable(out_err));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_data == '0);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !out_valid);

  p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_row < m_q);

  p_last_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_row == m_q - ONE |=> done);
endmodule

// File: tb/detprob_engine_tb.sv
module detprob_engine_tb;
  localparam int DW = 32;
  localparam int DIM_W = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [DIM_W-1:0] dim_in = '0;
  logic [DW-1:0] scale_in = '0, in_data = '0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, out_err, done;
  logic [DW-1:0] out_data;
  logic [DIM_W-1:0] out_row;

  int checks = 0, errors = 0;
  int mat [0:63];
  int cyc = 0;

  always #4 clk = ~clk;

  detprob_engine #(.DW(DW), .DIM_W(DIM_W)) u_dut (
    .clk, .rst_n, .start, .dim_in, .scale_in, .in_valid, .in_data, .in_ready,
    .out_valid, .out_ready, .out_data, .out_row, .out_err, .done);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int m, input int r, input int sc, output bit err);
    int s = 0;
    longint p, q;
    for (int c = 0; c < m; c++) s += mat[r*m + c];
    err = (s == 0);
    if (err) return 0;
    p = longint'(mat[r*m + r]) * longint'(sc);
    q = p / longint'(s);
    return int'(q[31:0]);
  endfunction

  task automatic feed(input int m);
    for (int i = 0; i < m*m; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) @(negedge clk);
      in_valid = 1; in_data = mat[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic drain(input int m, input int sc);
    int got = 0;
    bit pend = 0;
    logic [DW-1:0] pd; logic [DIM_W-1:0] pr; logic pe;
    while (got < m) begin
      out_ready = ($urandom_range(0, 3) != 0);
      if (pend) begin
        chk("R6 valid held", out_valid, 1);
        chk("R6 data held", {pe, pr, pd} == {out_err, out_row, out_data}, 1);
      end
      pend = 0;
      if (out_valid) begin
        chk("R2 no input during output", in_ready, 0);
        if (out_ready) begin
          bit e; int ex;
          ex = exp_res(m, got, sc, e);
          chk("R4 row order", out_row, got);
          chk("R3 R9 result", $signed(out_data), ex);
          chk("R5 err flag", out_err, e);
          got++;
        end else begin
          pend = 1; pd = out_data; pr = out_row; pe = out_err;
        end
      end
      @(negedge clk);
    end
    out_ready = 0;
    chk("R7 done after last", done, 1);
    chk("R4 no extra result", out_valid, 0);
  endtask

  task automatic run(input int m, input int sc);
    @(negedge clk);
    start = 1; dim_in = DIM_W'(m); scale_in = sc;
    @(negedge clk);
    start = 0;
    chk("R7 done cleared by start", done, 0);
    fork
      feed(m);
      drain(m, sc);
    join
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in_ready reset", in_ready, 0);
    chk("R1 out_valid reset", out_valid, 0);
    chk("R1 done reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle in_ready", in_ready, 0);

    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 16; i++) mat[i] = $urandom_range(0, 999);
      run(4, 100000);
    end

    for (int i = 0; i < 16; i++) mat[i] = $urandom_range(1, 50);
    for (int c = 0; c < 4; c++) mat[2*4 + c] = 0;
    run(4, 100000);   // R5 zero-sum row

    for (int i = 0; i < 16; i++) mat[i] = int'($urandom_range(0, 400)) - 200;
    mat[0] = -7; mat[1] = 3; mat[2] = 1; mat[3] = 0;
    run(4, 100000);   // R9 negative counts

    mat[0] = 5; mat[1] = 3; mat[2] = -8;
    mat[3] = 0; mat[4] = 9; mat[5] = 0;
    mat[6] = 1; mat[7] = 1; mat[8] = 1;
    run(3, 777);      // R8 dimension 3, other scale

    mat[0] = 37;
    run(1, 1000);     // R8 dimension 1

    @(negedge clk);
    start = 1; dim_in = '0; scale_in = 5;
    @(negedge clk);
    start = 0;
    chk("R8 zero dimension done", done, 1);
    chk("R8 zero dimension no output", out_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule